// File: doc/BRIEF.md
# Mode-Banked Processor Register File

This block holds the architectural state of a 32-bit processor core: sixteen indexed registers, a current status word and one saved status word per privileged mode. The core presents a 5-bit processor mode, and the block uses it to steer every indexed access to a physical slot. Privileged modes therefore see private copies of selected registers. The fast-interrupt mode swaps out seven registers, from index 8 to index 14. The other four privileged modes swap out only the stack pointer (index 13) and the link register (index 14).

The core reads two operands through combinational read ports and writes one result per clock through a single write port. It reads and writes the current status word directly. It reaches the saved status word of the present mode through a separate port. When the core takes an exception it raises an entry strobe with the target mode and the return address. In that cycle the block places the return address in the target mode's link register and copies the prior current status word into the target mode's saved status word. Index 15 is the program counter, kept here as a plain storage slot and never advanced by this block.

Top module: `banked_regfile`

## Requirements
- R1: On a clock edge with `rst_n` low, every indexed register and every saved status word becomes zero, and the current status word becomes 32'h0000_0013 (supervisor encoding in bits 4:0).
- R2: A write with `wr_en` high lands at the rising edge. Both read ports return the stored value combinationally. Index 15 behaves as an ordinary storage slot in every mode.
- R3: In fast-interrupt mode (10001), indices 8 to 14 reach a private set of seven registers, and indices 0 to 7 and 15 reach the shared set.
- R4: In interrupt (10010), supervisor (10011), abort (10111) and undefined (11011) modes, indices 13 and 14 reach a pair private to that mode, and all other indices reach the shared set.
- R5: User (10000) and system (11111) modes reach the same shared set. Any other mode encoding is treated as user mode.
- R6: Each of the five privileged modes has its own saved status word. The saved-status port reads and writes the copy belonging to the mode on `mode_i`.
- R7: In user mode, system mode or an unrecognised mode, the saved-status port reads back the current status word and ignores writes.
- R8: With `exc_en` high, the edge writes `exc_ret` into index 14 of the bank of `exc_mode`. For a privileged target, the same edge writes the current status word held before that edge into the target's saved status word.
- R9: If exception entry and an ordinary write (register or saved status) hit the same physical location in one cycle, the exception entry value is kept.
- R10: With `cpsr_we` high, the current status word takes `cpsr_wdata` at the edge and is returned on `cpsr_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_i | input | 5 | Current processor mode, selects the bank |
| rd0_idx | input | 4 | Read port 0 register index |
| rd0_data | output | 32 | Read port 0 data |
| rd1_idx | input | 4 | Read port 1 register index |
| rd1_data | output | 32 | Read port 1 data |
| wr_en | input | 1 | Register write enable |
| wr_idx | input | 4 | Register write index |
| wr_data | input | 32 | Register write data |
| cpsr_we | input | 1 | Current status write enable |
| cpsr_wdata | input | 32 | Current status write data |
| cpsr_rdata | output | 32 | Current status word |
| spsr_we | input | 1 | Saved status write enable |
| spsr_wdata | input | 32 | Saved status write data |
| spsr_rdata | output | 32 | Saved status word of the current mode |
| exc_en | input | 1 | Exception entry strobe |
| exc_mode | input | 5 | Target mode of the exception |
| exc_ret | input | 32 | Return address for the target link register |

## Verification
A wrong bank mapping does not show until a read in some mode hits an aliased index. It then appears as another mode's value on a read port, combinationally, in the cycle after the write. The bench fills every index in every mode with a distinct value and then reads every index in every mode. Any misrouted slot therefore appears as a foreign value during the first sweep. A lost or misdirected exception capture shows at the link register and saved-status reads one cycle after the strobe. A priority fault shows in that same cycle as the ordinary write's data appearing in place of the return address or the saved status word.

// File: rtl/bank_pkg.sv
`timescale 1ns/1ps
// Package: shared mode encodings, bank identifiers and physical layout
// constants for the banked register file.
package bank_pkg;
    localparam logic [4:0] M_USR = 5'b10000;
    localparam logic [4:0] M_FIQ = 5'b10001;
    localparam logic [4:0] M_IRQ = 5'b10010;
    localparam logic [4:0] M_SVC = 5'b10011;
    localparam logic [4:0] M_ABT = 5'b10111;
    localparam logic [4:0] M_UND = 5'b11011;
    localparam logic [4:0] M_SYS = 5'b11111;

    typedef enum logic [2:0] {
        BK_USR = 3'd0,
        BK_FIQ = 3'd1,
        BK_IRQ = 3'd2,
        BK_SVC = 3'd3,
        BK_ABT = 3'd4,
        BK_UND = 3'd5
    } bank_e;

    localparam int NREG       = 16;
    localparam int FIQ_LO     = 8;
    localparam int FIQ_CNT    = 7;
    localparam int PAIR_LO    = 13;
    localparam int PAIR_CNT   = 2;
    localparam int N_PAIRMODE = 4;
    localparam int FIQ_BASE   = NREG;
    localparam int PAIR_BASE  = FIQ_BASE + FIQ_CNT;
    localparam int NPHYS      = PAIR_BASE + N_PAIRMODE * PAIR_CNT;
    localparam int N_SAVED    = N_PAIRMODE + 1;
    localparam int PW         = $clog2(NPHYS);
endpackage

// File: rtl/bank_mode_decode.sv
`timescale 1ns/1ps
// Module: bank_mode_decode
// Turns a 5-bit mode encoding into a bank identifier.
// Assumes any encoding outside the seven defined modes behaves as user mode.
module bank_mode_decode
    import bank_pkg::*;
(
    input  logic [4:0] mode,
    output bank_e      bank
);
    // Map the mode encoding to its bank, user bank by default.
    always_comb begin
        case (mode)
            M_FIQ:   bank = BK_FIQ;
            M_IRQ:   bank = BK_IRQ;
            M_SVC:   bank = BK_SVC;
            M_ABT:   bank = BK_ABT;
            M_UND:   bank = BK_UND;
            default: bank = BK_USR;
        endcase
    end
endmodule

// File: rtl/bank_index_map.sv
`timescale 1ns/1ps
// Module: bank_index_map
// Turns an architectural index and a bank into a physical slot number.
// Layout: slots 0..15 shared, then the seven fast-interrupt slots, then
// one pair per remaining privileged mode in bank order.
// Assumes bank values beyond BK_UND never occur.
module bank_index_map
    import bank_pkg::*;
(
    input  bank_e         bank,
    input  logic [3:0]    idx,
    output logic [PW-1:0] phys
);
    // Select the private slot when the bank owns this index.
    always_comb begin
        phys = PW'(idx);
        if (bank == BK_FIQ && int'(idx) >= FIQ_LO && int'(idx) < FIQ_LO + FIQ_CNT)
            phys = PW'(FIQ_BASE + int'(idx) - FIQ_LO);
        else if (bank != BK_USR && bank != BK_FIQ &&
                 int'(idx) >= PAIR_LO && int'(idx) < PAIR_LO + PAIR_CNT)
            phys = PW'(PAIR_BASE + PAIR_CNT * (int'(bank) - int'(BK_IRQ))
                       + int'(idx) - PAIR_LO);
    end
endmodule

// File: rtl/saved_status_bank.sv
`timescale 1ns/1ps
// Module: saved_status_bank
// Holds one saved status word per privileged bank. Exception entry copies
// the current status word into the target's entry and wins over a port
// write to the same entry. In the user bank, reads return the current
// status word and writes are dropped.
// Assumes cur_bank and exc_bank come from bank_mode_decode.
module saved_status_bank
    import bank_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  bank_e           cur_bank,
    input  bank_e           exc_bank,
    input  logic            we,
    input  logic [XLEN-1:0] wdata,
    input  logic            exc_en,
    input  logic [XLEN-1:0] cur_status,
    output logic [XLEN-1:0] rdata
);
    logic [XLEN-1:0] saved [N_SAVED];

    for (genvar k = 0; k < N_SAVED; k++) begin : g_entry
        localparam bank_e OWNER = bank_e'(k + 1);
        // Update one entry: exception capture first, else a port write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                saved[k] <= '0;
            else if (exc_en && exc_bank == OWNER)
                saved[k] <= cur_status;
            else if (we && cur_bank == OWNER)
                saved[k] <= wdata;
        end
    end

    // Present the entry of the current bank, or the live status in user bank.
    always_comb begin
        rdata = cur_status;
        for (int k = 0; k < N_SAVED; k++)
            if (cur_bank == bank_e'(k + 1)) rdata = saved[k];
    end
endmodule

// File: rtl/banked_regfile.sv
`timescale 1ns/1ps
// Module: banked_regfile
// Register file with two combinational read ports and one write port.
// Physical slots are chosen by the processor mode. It also holds the
// current status word and the per-mode saved status words, and captures
// the return address and status on exception entry.
// Assumes the program counter is advanced outside; index 15 is storage only.
module banked_regfile
    import bank_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [4:0]      mode_i,
    input  logic [3:0]      rd0_idx,
    output logic [XLEN-1:0] rd0_data,
    input  logic [3:0]      rd1_idx,
    output logic [XLEN-1:0] rd1_data,
    input  logic            wr_en,
    input  logic [3:0]      wr_idx,
    input  logic [XLEN-1:0] wr_data,
    input  logic            cpsr_we,
    input  logic [XLEN-1:0] cpsr_wdata,
    output logic [XLEN-1:0] cpsr_rdata,
    input  logic            spsr_we,
    input  logic [XLEN-1:0] spsr_wdata,
    output logic [XLEN-1:0] spsr_rdata,
    input  logic            exc_en,
    input  logic [4:0]      exc_mode,
    input  logic [XLEN-1:0] exc_ret
);
    localparam int NPORT = 4;  // rd0, rd1, wr, exception link
    localparam logic [3:0] LINK_IDX = 4'(PAIR_LO + 1);
    localparam logic [XLEN-1:0] STATUS_RST = XLEN'(M_SVC);

    bank_e           cur_bank, exc_bank;
    bank_e           port_bank [NPORT];
    logic [3:0]      port_idx  [NPORT];
    logic [PW-1:0]   port_phys [NPORT];
    logic [XLEN-1:0] regs [NPHYS];
    logic [XLEN-1:0] status_q;

    bank_mode_decode u_cur_dec (.mode(mode_i),   .bank(cur_bank));
    bank_mode_decode u_exc_dec (.mode(exc_mode), .bank(exc_bank));

    // Gather the bank and index of every access path.
    always_comb begin
        port_bank[0] = cur_bank;  port_idx[0] = rd0_idx;
        port_bank[1] = cur_bank;  port_idx[1] = rd1_idx;
        port_bank[2] = cur_bank;  port_idx[2] = wr_idx;
        port_bank[3] = exc_bank;  port_idx[3] = LINK_IDX;
    end

    for (genvar p = 0; p < NPORT; p++) begin : g_map
        bank_index_map u_map (
            .bank (port_bank[p]),
            .idx  (port_idx[p]),
            .phys (port_phys[p])
        );
    end

    // Register array update: ordinary write unless the exception hits the same slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NPHYS; i++) regs[i] <= '0;
        end else begin
            if (wr_en && !(exc_en && port_phys[2] == port_phys[3]))
                regs[port_phys[2]] <= wr_data;
            if (exc_en)
                regs[port_phys[3]] <= exc_ret;
        end
    end

    // Current status word register.
    always_ff @(posedge clk) begin
        if (!rst_n)       status_q <= STATUS_RST;
        else if (cpsr_we) status_q <= cpsr_wdata;
    end

    saved_status_bank #(.XLEN(XLEN)) u_saved (
        .clk        (clk),
        .rst_n      (rst_n),
        .cur_bank   (cur_bank),
        .exc_bank   (exc_bank),
        .we         (spsr_we),
        .wdata      (spsr_wdata),
        .exc_en     (exc_en),
        .cur_status (status_q),
        .rdata      (spsr_rdata)
    );

    // Drive the read outputs from storage.
    always_comb begin
        rd0_data   = regs[port_phys[0]];
        rd1_data   = regs[port_phys[1]];
        cpsr_rdata = status_q;
    end
endmodule

// File: rtl/banked_regfile_chk.sv
`timescale 1ns/1ps
// Module: banked_regfile_chk
// Port-level properties of banked_regfile, attached through bind.
module banked_regfile_chk
    import bank_pkg::*;
#(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic [4:0]      mode_i,
    input logic [3:0]      rd0_idx,
    input logic [XLEN-1:0] rd0_data,
    input logic [3:0]      rd1_idx,
    input logic [XLEN-1:0] rd1_data,
    input logic            wr_en,
    input logic [3:0]      wr_idx,
    input logic [XLEN-1:0] wr_data,
    input logic            cpsr_we,
    input logic [XLEN-1:0] cpsr_wdata,
    input logic [XLEN-1:0] cpsr_rdata,
    input logic            spsr_we,
    input logic [XLEN-1:0] spsr_wdata,
    input logic [XLEN-1:0] spsr_rdata,
    input logic            exc_en,
    input logic [4:0]      exc_mode,
    input logic [XLEN-1:0] exc_ret
);
    logic priv_now, plain_now;

    // Classify the current mode for the properties.
    always_comb begin
        priv_now  = (mode_i == M_FIQ) || (mode_i == M_IRQ) || (mode_i == M_SVC) ||
                    (mode_i == M_ABT) || (mode_i == M_UND);
        plain_now = (mode_i == M_USR) || (mode_i == M_SYS);
    end

    p_reset_status_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> cpsr_rdata == XLEN'(M_SVC));

    p_write_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !exc_en) |=>
            (!($stable(mode_i) && rd0_idx == $past(wr_idx)) || rd0_data == $past(wr_data)));

    p_plain_saved_r7: assert property (@(posedge clk) disable iff (!rst_n)
        plain_now |-> spsr_rdata == cpsr_rdata);

    p_exc_status_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_en && priv_now && exc_mode == mode_i) |=>
            (!$stable(mode_i) || spsr_rdata == $past(cpsr_rdata)));

    p_exc_link_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_en && exc_mode == mode_i) |=>
            (!($stable(mode_i) && rd0_idx == 4'd14) || rd0_data == $past(exc_ret)));

    p_status_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cpsr_we |=> cpsr_rdata == $past(cpsr_wdata));
endmodule

bind banked_regfile banked_regfile_chk #(.XLEN(XLEN)) u_chk (.*);

// File: tb/sim_banked_regfile.sv
`timescale 1ns/1ps
module sim_banked_regfile;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  mode_i = 5'b10000;
    logic [3:0]  rd0_idx = '0, rd1_idx = '0, wr_idx = '0;
    logic [31:0] rd0_data, rd1_data, cpsr_rdata, spsr_rdata;
    logic        wr_en = 1'b0, cpsr_we = 1'b0, spsr_we = 1'b0, exc_en = 1'b0;
    logic [31:0] wr_data = '0, cpsr_wdata = '0, spsr_wdata = '0, exc_ret = '0;
    logic [4:0]  exc_mode = 5'b10000;

    int checks = 0, errors = 0;
    bit done = 1'b0;
    logic [31:0] pm  [0:299];
    logic [31:0] ssm [0:7];
    logic [31:0] cur_status;

    always #5 clk = ~clk;

    banked_regfile u0 (.*);

    // Mode list: 0 user, 1 fast-int, 2 irq, 3 svc, 4 abort, 5 undef, 6 system, 7 bogus
    function automatic logic [4:0] mode_of(int k);
        case (k)
            0: return 5'b10000;  1: return 5'b10001;  2: return 5'b10010;
            3: return 5'b10011;  4: return 5'b10111;  5: return 5'b11011;
            6: return 5'b11111;  default: return 5'b00101;
        endcase
    endfunction

    // Storage slot that the requirements imply for mode k, index i.
    function automatic int slot_of(int k, int i);
        if (k == 1 && i >= 8 && i <= 14) return 100 + i;
        if (k >= 2 && k <= 5 && (i == 13 || i == 14)) return 200 + 10 * k + i;
        return i;
    endfunction

    function automatic string rtag(int k, int i);
        if (k == 1 && i >= 8 && i <= 14) return "R2 R3";
        if (k >= 2 && k <= 5 && i >= 13 && i <= 14) return "R2 R4";
        return "R2 R5";
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic sweep_regs();
        for (int k = 0; k < 8; k++) begin
            mode_i = mode_of(k);
            for (int i = 0; i < 16; i++) begin
                rd0_idx = 4'(i);
                rd1_idx = 4'(15 - i);
                #1;
                chk(rtag(k, i), rd0_data, pm[slot_of(k, i)]);
                chk(rtag(k, 15 - i), rd1_data, pm[slot_of(k, 15 - i)]);
            end
        end
    endtask

    task automatic sweep_saved();
        for (int k = 0; k < 8; k++) begin
            mode_i = mode_of(k);
            #1;
            if (k >= 1 && k <= 5) chk("R6", spsr_rdata, ssm[k]);
            else                  chk("R7", spsr_rdata, cur_status);
        end
    endtask

    initial begin
        for (int s = 0; s < 300; s++) pm[s] = '0;
        for (int k = 0; k < 8; k++) ssm[k] = '0;
        cur_status = 32'h0000_0013;
        repeat (2) tick();
        rst_n = 1'b1;
        #1;
        // R1: reset state
        chk("R1", cpsr_rdata, 32'h0000_0013);
        sweep_regs();
        sweep_saved();

        // R2..R5: fill every index of every mode with a distinct value
        for (int k = 0; k < 8; k++) begin
            mode_i = mode_of(k);
            for (int i = 0; i < 16; i++) begin
                wr_en = 1'b1;
                wr_idx = 4'(i);
                wr_data = 32'hC000_0000 | (k << 8) | i;
                tick();
                pm[slot_of(k, i)] = wr_data;
            end
        end
        wr_en = 1'b0;
        sweep_regs();

        // R10: current status write
        cpsr_we = 1'b1;
        cpsr_wdata = 32'h8000_001F;
        tick();
        cpsr_we = 1'b0;
        cur_status = 32'h8000_001F;
        chk("R10", cpsr_rdata, cur_status);

        // R6, R7: saved status writes in every mode
        for (int k = 0; k < 8; k++) begin
            mode_i = mode_of(k);
            spsr_we = 1'b1;
            spsr_wdata = 32'h5500_0000 | k;
            tick();
            if (k >= 1 && k <= 5) ssm[k] = spsr_wdata;
        end
        spsr_we = 1'b0;
        sweep_saved();

        // R8, R9: exception entry into each privileged mode, colliding writes
        for (int k = 1; k <= 5; k++) begin
            mode_i = mode_of(k);
            cpsr_we = 1'b1;
            cpsr_wdata = 32'h2000_0000 | k;
            tick();
            cur_status = cpsr_wdata;
            exc_en = 1'b1;
            exc_mode = mode_of(k);
            exc_ret = 32'hE000_0000 | (k << 4);
            wr_en = 1'b1;  wr_idx = 4'd14;  wr_data = 32'hBAD0_0000 | k;
            spsr_we = 1'b1; spsr_wdata = 32'hBAD1_0000 | k;
            cpsr_wdata = 32'h3000_0000 | k;
            tick();
            exc_en = 1'b0; wr_en = 1'b0; spsr_we = 1'b0; cpsr_we = 1'b0;
            pm[slot_of(k, 14)] = exc_ret;
            ssm[k] = cur_status;
            cur_status = 32'h3000_0000 | k;
            rd0_idx = 4'd14;
            #1;
            chk("R8 R9 link", rd0_data, exc_ret);
            chk("R8 R9 saved", spsr_rdata, ssm[k]);
            chk("R10", cpsr_rdata, cur_status);
        end

        // R8: entry into fast-interrupt while running in user mode, with an unrelated write
        mode_i = 5'b10000;
        exc_en = 1'b1;
        exc_mode = 5'b10001;
        exc_ret = 32'h1234_5678;
        wr_en = 1'b1; wr_idx = 4'd3; wr_data = 32'h0000_3333;
        tick();
        exc_en = 1'b0; wr_en = 1'b0;
        pm[slot_of(1, 14)] = 32'h1234_5678;
        pm[slot_of(0, 3)] = 32'h0000_3333;
        ssm[1] = cur_status;
        rd0_idx = 4'd14; rd1_idx = 4'd3;
        #1;
        chk("R8 user link untouched", rd0_data, pm[slot_of(0, 14)]);
        chk("R2 concurrent write", rd1_data, 32'h0000_3333);

        // R8: entry targeting system mode writes the shared link only
        exc_en = 1'b1;
        exc_mode = 5'b11111;
        exc_ret = 32'h0BAD_F00D;
        tick();
        exc_en = 1'b0;
        pm[slot_of(6, 14)] = 32'h0BAD_F00D;

        sweep_regs();
        sweep_saved();

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule